// File: doc/BRIEF.md
# Ring and Polarity Period Meter

This block sits behind two already-synchronized line comparators, called line A and line B. It turns their level changes into interrupt event pulses and measures the time of each B-A-B ring cycle. A falling edge on line A and a rising edge on line B each produce a one-cycle event pulse, but only while the interrupt enable input is high. The block also keeps the registered level of each line as a status output.

A free-running time base delivers a one-cycle tick at 2048 Hz. A saturating counter restarts on every line B event and counts these ticks. When a line B event closes a cycle in which at least one line A event came after the previous line B event, the counter value is stored in the 8-bit period register. In every other case the register is loaded with 255. These cases are the first line B event after reset, a repeated line B event with no line A event in between, and a cycle longer than 255 ticks (the counter stops at 255). The period register reads 255 after reset.

Top module: `ring_period_unit`

## Requirements
- R1: `stat_a_o` and `stat_b_o` equal the values of `line_a_i` and `line_b_i` one clock edge earlier. Both read 0 while `rst` is high. They track the lines whatever the value of `irq_en_i`.
- R2: `evt_a_o` is 1 for the one cycle after an edge at which `stat_a_o` was 1 and `line_a_i` was 0, provided `irq_en_i` was 1 at that edge.
- R3: `evt_b_o` is 1 for the one cycle after an edge at which `stat_b_o` was 0 and `line_b_i` was 1, provided `irq_en_i` was 1 at that edge.
- R4: While `irq_en_i` is 0, no event pulse is produced. An edge that happens while events are disabled does not fire later when they are re-enabled.
- R5: `period_o` reads 255 and both event outputs read 0 in the cycle after a reset edge.
- R6: The first line B event after reset loads 255 into `period_o`.
- R7: A line B event that follows an earlier line B event, with at least one line A event after that earlier one, loads `period_o` with the number of tick edges in between. The count covers the edges after the earlier event's edge and before the current one. A tick that coincides with a line B event edge is not counted.
- R8: The tick count saturates at 255. A cycle with more than 255 counted ticks stores 255.
- R9: Two line B events with no line A event between them store 255.
- R10: `period_o` changes only in a cycle where `evt_b_o` is 1. Line edges suppressed by R4 neither update it nor count as a line A event for a later cycle.
- R11: Each event pulse lasts exactly one cycle; `evt_b_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse at 2048 Hz |
| irq_en_i | input | 1 | Enables line event generation |
| line_a_i | input | 1 | Synchronized line A comparator level |
| line_b_i | input | 1 | Synchronized line B comparator level |
| stat_a_o | output | 1 | Registered line A level |
| stat_b_o | output | 1 | Registered line B level |
| evt_a_o | output | 1 | Line A falling-edge event pulse |
| evt_b_o | output | 1 | Line B rising-edge event pulse |
| period_o | output | 8 | Last measured ring period in 1/2048 s units |

## Verification
The hardest case to reach is a cycle whose stored value is exact rather than saturated. It needs a line B event, then a line A event, then a second line B event, all within 255 ticks. A tick must also fall on the closing edge, where it must be ignored. Random line toggling at realistic rates almost never produces this, so directed sequences drive an exact number of ticks between the events. A random phase follows with fast line toggling, dense ticks and occasional enable drops. A cycle-level bench model checks every output on every cycle of that phase.

// File: rtl/ring_meas_pkg.sv
package ring_meas_pkg;

  // Number of comparator lines handled by the block.
  localparam int NUM_LINES = 2;
  localparam int LINE_A    = 0;
  localparam int LINE_B    = 1;

  // Edge that produces an event on a line.
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;

  // Edge kind assigned to each line index.
  function automatic edge_kind_e line_edge_kind(input int idx);
    return (idx == LINE_A) ? EDGE_FALL : EDGE_RISE;
  endfunction

endpackage

// File: rtl/line_edge_det.sv
module line_edge_det
  import ring_meas_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic gate_i,
  output logic stat_o,
  output logic hit_o,
  output logic pulse_o
);

  logic edge_seen;

  // Edge qualification against the registered level.
  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign edge_seen = level_i & ~stat_o;
    end else begin : g_fall
      assign edge_seen = ~level_i & stat_o;
    end
  endgenerate

  assign hit_o = edge_seen & gate_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      stat_o  <= level_i;
      pulse_o <= hit_o;
    end
  end

endmodule

// File: rtl/sat_tick_counter.sv
module sat_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      count_o <= '0;
    end else if (tick_i && (count_o != CNT_MAX)) begin
      count_o <= count_o + 1'b1;
    end
  end

endmodule

// File: rtl/period_tracker.sv
module period_tracker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mark_a_i,
  input  logic         mark_b_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] period_o
);

  localparam logic [W-1:0] PER_MAX = {W{1'b1}};

  logic armed_q;   // a line B event was seen since reset
  logic seen_a_q;  // a line A event was seen since the last line B event
  logic valid_cycle;

  assign valid_cycle = armed_q & seen_a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      seen_a_q <= 1'b0;
      period_o <= PER_MAX;
    end else if (mark_b_i) begin
      armed_q  <= 1'b1;
      seen_a_q <= mark_a_i;
      period_o <= valid_cycle ? count_i : PER_MAX;
    end else if (mark_a_i) begin
      seen_a_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ring_period_unit.sv
module ring_period_unit
  import ring_meas_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                irq_en_i,
  input  logic                line_a_i,
  input  logic                line_b_i,
  output logic                stat_a_o,
  output logic                stat_b_o,
  output logic                evt_a_o,
  output logic                evt_b_o,
  output logic [PERIOD_W-1:0] period_o
);

  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] stat;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] pulse;
  logic [PERIOD_W-1:0]  tick_count;

  assign lvl[LINE_A] = line_a_i;
  assign lvl[LINE_B] = line_b_i;

  generate
    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
      line_edge_det #(
        .KIND(line_edge_kind(gi))
      ) u_det (
        .clk    (clk),
        .rst    (rst),
        .level_i(lvl[gi]),
        .gate_i (irq_en_i),
        .stat_o (stat[gi]),
        .hit_o  (hit[gi]),
        .pulse_o(pulse[gi])
      );
    end
  endgenerate

  sat_tick_counter #(
    .W(PERIOD_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clear_i(hit[LINE_B]),
    .tick_i (tick_i),
    .count_o(tick_count)
  );

  period_tracker #(
    .W(PERIOD_W)
  ) u_trk (
    .clk     (clk),
    .rst     (rst),
    .mark_a_i(hit[LINE_A]),
    .mark_b_i(hit[LINE_B]),
    .count_i (tick_count),
    .period_o(period_o)
  );

  assign stat_a_o = stat[LINE_A];
  assign stat_b_o = stat[LINE_B];
  assign evt_a_o  = pulse[LINE_A];
  assign evt_b_o  = pulse[LINE_B];

endmodule

// File: rtl/ring_period_chk.sv
module ring_period_chk #(
  parameter int PERIOD_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                irq_en_i,
  input logic                line_a_i,
  input logic                line_b_i,
  input logic                stat_a_o,
  input logic                stat_b_o,
  input logic                evt_a_o,
  input logic                evt_b_o,
  input logic [PERIOD_W-1:0] period_o
);

  localparam logic [PERIOD_W-1:0] FULL = {PERIOD_W{1'b1}};

  assert_status_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stat_a_o == $past(line_a_i)) && (stat_b_o == $past(line_b_i)));

  assert_a_event_edge_R2: assert property (@(posedge clk) disable iff (rst)
    evt_a_o |-> ($past(stat_a_o) && !stat_a_o));

  assert_b_event_edge_R3: assert property (@(posedge clk) disable iff (rst)
    evt_b_o |-> (!$past(stat_b_o) && stat_b_o));

  assert_events_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_a_o || evt_b_o) |-> $past(irq_en_i));

  assert_reset_state_R5: assert property (@(posedge clk)
    rst |=> (period_o == FULL && !evt_a_o && !evt_b_o));

  assert_period_update_R10: assert property (@(posedge clk) disable iff (rst)
    (period_o != $past(period_o)) |-> evt_b_o);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    evt_b_o |=> !evt_b_o);

endmodule

bind ring_period_unit ring_period_chk #(
  .PERIOD_W(PERIOD_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_en_i(irq_en_i),
  .line_a_i(line_a_i),
  .line_b_i(line_b_i),
  .stat_a_o(stat_a_o),
  .stat_b_o(stat_b_o),
  .evt_a_o (evt_a_o),
  .evt_b_o (evt_b_o),
  .period_o(period_o)
);

// File: tb/sim_ring_period_unit.sv
`timescale 1ns/1ps
module sim_ring_period_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic       la = 1'b0;
  logic       lb = 1'b0;
  logic       sa, sb, ea, eb;
  logic [7:0] per;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic m_sa, m_sb, m_ea, m_eb, m_seen, m_armed;
  int   m_cnt, m_per;

  always #10 clk = ~clk;

  ring_period_unit #(.PERIOD_W(8)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .irq_en_i(en),
    .line_a_i(la), .line_b_i(lb),
    .stat_a_o(sa), .stat_b_o(sb), .evt_a_o(ea), .evt_b_o(eb),
    .period_o(per)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock with model update; model computed from requirements
  task automatic step();
    logic ha, hb;
    int   n_cnt;
    ha = en & m_sa & ~la;
    hb = en & ~m_sb & lb;
    n_cnt = m_cnt;
    @(posedge clk);
    if (rst) begin
      m_sa = 0; m_sb = 0; m_ea = 0; m_eb = 0;
      m_cnt = 0; m_seen = 0; m_armed = 0; m_per = 255;
    end else begin
      if (hb) begin
        m_per   = (m_armed && m_seen) ? m_cnt : 255;
        n_cnt   = 0;
        m_seen  = ha;
        m_armed = 1;
      end else begin
        if (tick && n_cnt < 255) n_cnt = n_cnt + 1;
        if (ha) m_seen = 1;
      end
      m_cnt = n_cnt;
      m_sa = la; m_sb = lb; m_ea = ha; m_eb = hb;
    end
    @(negedge clk);
    check("R1", {sa, sb}, {m_sa, m_sb});
    check("R2", ea, m_ea);
    check("R3", eb, m_eb);
    check("R7", per, m_per);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
    end
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1337));
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    // R5: reset state
    check("R5", per, 255);
    check("R5", {ea, eb}, 0);
    check("R1", {sa, sb}, 0);

    en = 1'b1;
    la = 1'b1; step();
    check("R2", ea, 0);
    // R6: first line B event keeps 255
    lb = 1'b1; step();
    check("R3", eb, 1);
    check("R6", per, 255);
    step();
    check("R11", eb, 0);
    // R7: exact cycle of 10 ticks, tick on closing edge ignored
    lb = 1'b0; step();
    la = 1'b0; step();
    check("R2", ea, 1);
    step();
    check("R11", ea, 0);
    ticks(10);
    tick = 1'b1; lb = 1'b1; step(); tick = 1'b0;
    check("R7", per, 10);
    // R9: repeated line B event with no line A event
    lb = 1'b0; ticks(3);
    lb = 1'b1; step();
    check("R9", per, 255);
    // exact small cycle: 1 tick
    lb = 1'b0; la = 1'b1; step();
    la = 1'b0; ticks(1);
    lb = 1'b1; step();
    check("R7", per, 1);
    // R8: saturation
    lb = 1'b0; la = 1'b1; step();
    la = 1'b0; ticks(300);
    lb = 1'b1; step();
    check("R8", per, 255);
    // exactly 255 ticks
    lb = 1'b0; la = 1'b1; step();
    la = 1'b0; ticks(255);
    lb = 1'b1; step();
    check("R8", per, 255);
    // 254 ticks measured exactly
    lb = 1'b0; la = 1'b1; step();
    la = 1'b0; ticks(254);
    lb = 1'b1; step();
    check("R7", per, 254);
    // R4 / R10: disabled edges
    la = 1'b1; lb = 1'b0; step();
    en = 1'b0; la = 1'b0; step();
    check("R4", ea, 0);
    check("R1", sa, 0);
    lb = 1'b1; ticks(4);
    check("R4", eb, 0);
    check("R10", per, 254);
    en = 1'b1; step();
    check("R4", eb, 0);
    lb = 1'b0; step();
    lb = 1'b1; step();
    check("R3", eb, 1);
    check("R10", per, 255);

    // Random phase checked against the model every cycle
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 15) == 0) la = ~la;
      if ($urandom_range(0, 23) == 0) lb = ~lb;
      tick = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 199) == 0) en = ~en;
      if (i == 10000) rst = 1'b1;
      if (i == 10002) rst = 1'b0;
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule